// File: doc/BRIEF.md
# Instruction Word Field Decoder

This combinational block takes one 32-bit instruction word and its valid bit. It returns every field the later pipeline stages need, plus a bundle of control strobes. The two most significant bits of the word pick one of four layouts: load, store, register-to-register arithmetic, or control transfer. Each layout places its register indices and constants at fixed positions. The decoder moves them onto a common set of outputs. Index fields that a layout does not carry read as zero.

The control bundle has the following strobes:
- register-file write enable
- memory read and memory write strobes
- an operand select that picks the constant over the second register
- a 3-bit control-transfer kind
- a one-cycle stall request for the no-op function
- an illegal-instruction flag

Control-transfer targets are absolute. The 20-bit address field is zero-extended and handed out unchanged. No program-counter offset is added. The valid input gates only the control bundle. The field outputs always follow the word.

Top module: `insn_field_decoder`

## Requirements
- R1: `cat_o` equals instruction bits 31:30, with 0 = load, 1 = store, 2 = arithmetic and 3 = control transfer.
- R2: For loads and stores, `amode_o` is bits 29:24 and `rs1_o` (base) is bits 19:16. `imm_o` is bits 15:0 zero-extended. A load places bits 23:20 on `rd_o` and gives `rs2_o` = 0. A store places bits 23:20 on `rs2_o` and gives `rd_o` = 0.
- R3: For arithmetic words, `func_o` is bits 29:25, `rd_o` is bits 23:20, `rs1_o` is bits 19:16 and `rs2_o` is bits 15:12. `imm_o` is bits 11:0 zero-extended, and `amode_o` is 0.
- R4: For control-transfer words, `btype_o` is bits 29:26 and `amode_o` is bits 25:24 zero-extended. `rs1_o` is bits 23:20 and `rs2_o` is 0. `imm_o` is bits 19:0 zero-extended, as an absolute target with no offset added. `func_o` is 0 outside arithmetic words, and `btype_o` is 0 outside control-transfer words.
- R5: With valid high, `mem_rd_o` is 1 only for loads and `mem_wr_o` is 1 only for stores.
- R6: With valid high, `use_imm_o` is 1 for every load and store. For an arithmetic word it is 1 only when the function is legal, the word is not the no-op, and bit 24 is set. In every other case it is 0.
- R7: Function 11111 is the no-op. With valid high it raises `stall_o` and keeps `reg_we_o` and `use_imm_o` low, whatever the state of bit 24.
- R8: With valid high, `br_kind_o` maps the type field as follows: 0001 gives 1 (branch if zero), 0010 gives 2 (branch if non-zero), 0100 gives 3 (jump), 0110 gives 4 (jump via register) and 1000 gives 5 (subroutine jump). Anything else gives 0.
- R9: The subroutine jump (type 1000) gives `rd_o` = 15. With valid high it also raises `reg_we_o`.
- R10: With valid high, `reg_we_o` is 1 for loads, for legal arithmetic functions other than the no-op, and for the subroutine jump. It is 0 for stores and for every other control transfer.
- R11: The legal arithmetic functions are 00000, 00001, 00100, 00101, 00110, 00111, 01000 to 01101, 10000, 10010, 11000, 11100 and 11111. The legal control-transfer types are those listed in R8. With valid high, any other function or type raises `illegal_o` and holds `reg_we_o`, `mem_wr_o`, `stall_o`, `use_imm_o` and `br_kind_o` at 0.
- R12: With valid low, every control output is 0 (`reg_we_o`, `mem_rd_o`, `mem_wr_o`, `use_imm_o`, `stall_o`, `illegal_o`, `br_kind_o`). The field outputs still follow the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Word is valid; when low, the control outputs are gated off |
| insn_i | input | 32 | Instruction word |
| cat_o | output | 2 | Category from bits 31:30 |
| rd_o | output | 4 | Destination register index |
| rs1_o | output | 4 | First source or base register index |
| rs2_o | output | 4 | Second source or store-data register index |
| imm_o | output | XLEN | Zero-extended displacement, immediate or absolute target |
| amode_o | output | 6 | Addressing-mode field |
| func_o | output | 5 | Arithmetic function code |
| btype_o | output | 4 | Control-transfer type code |
| reg_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| use_imm_o | output | 1 | Second operand taken from `imm_o` |
| br_kind_o | output | 3 | Control-transfer kind per R8 |
| stall_o | output | 1 | One-cycle stall request for the no-op |
| illegal_o | output | 1 | Unrecognised function or type |

## Verification
Two gating paths can act on the same word: legality suppression and valid gating. The immediate flag can also coincide with the no-op or with an illegal function. The bench sweeps all 64 values of bits 29:24 in every category, with valid both low and high. This covers every function paired with both settings of the immediate flag, and every type paired with every addressing value. Each word is judged output by output against an arithmetic model in the bench. A no-op with bit 24 set must stall without selecting the constant. An illegal function with bit 24 set must raise only `illegal_o`.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int unsigned IW    = 32;
  localparam int unsigned RIDX  = 4;
  localparam int unsigned FUNCW = 5;
  localparam int unsigned BTW   = 4;
  localparam int unsigned AMW   = 6;
  localparam int unsigned RAWIW = 20;

  typedef enum logic [1:0] {
    CAT_LOAD  = 2'd0,
    CAT_STORE = 2'd1,
    CAT_ARITH = 2'd2,
    CAT_FLOW  = 2'd3
  } cat_e;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_BEQZ = 3'd1,
    BK_BNEZ = 3'd2,
    BK_JUMP = 3'd3,
    BK_JREG = 3'd4,
    BK_JSUB = 3'd5
  } brk_e;

  localparam logic [FUNCW-1:0] FN_NOP  = 5'b11111;
  localparam logic [BTW-1:0]   BT_JSUB = 4'b1000;

  function automatic logic func_legal(input logic [FUNCW-1:0] f);
    case (f)
      5'b00000, 5'b00001, 5'b00100, 5'b00101, 5'b00110, 5'b00111,
      5'b01000, 5'b01001, 5'b01010, 5'b01011, 5'b01100, 5'b01101,
      5'b10000, 5'b10010, 5'b11000, 5'b11100, 5'b11111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic brk_e type_kind(input logic [BTW-1:0] t);
    case (t)
      4'b0001: return BK_BEQZ;
      4'b0010: return BK_BNEZ;
      4'b0100: return BK_JUMP;
      4'b0110: return BK_JREG;
      4'b1000: return BK_JSUB;
      default: return BK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import insn_dec_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LINK_REG = 15
) (
  input  logic [IW-1:0]    insn,
  output cat_e             cat,
  output logic [RIDX-1:0]  rd,
  output logic [RIDX-1:0]  rs1,
  output logic [RIDX-1:0]  rs2,
  output logic [XLEN-1:0]  imm,
  output logic [AMW-1:0]   amode,
  output logic [FUNCW-1:0] func,
  output logic [BTW-1:0]   btype,
  output logic             imm_flag
);
  logic [RAWIW-1:0] imm_raw;

  always_comb begin
    cat      = cat_e'(insn[31:30]);
    rd       = '0;
    rs1      = '0;
    rs2      = '0;
    imm_raw  = '0;
    amode    = '0;
    func     = '0;
    btype    = '0;
    imm_flag = 1'b0;
    unique case (cat)
      CAT_LOAD: begin
        amode   = insn[29:24];
        rd      = insn[23:20];
        rs1     = insn[19:16];
        imm_raw = RAWIW'(insn[15:0]);
      end
      CAT_STORE: begin
        amode   = insn[29:24];
        rs2     = insn[23:20];
        rs1     = insn[19:16];
        imm_raw = RAWIW'(insn[15:0]);
      end
      CAT_ARITH: begin
        func     = insn[29:25];
        imm_flag = insn[24];
        rd       = insn[23:20];
        rs1      = insn[19:16];
        rs2      = insn[15:12];
        imm_raw  = RAWIW'(insn[11:0]);
      end
      CAT_FLOW: begin
        btype   = insn[29:26];
        amode   = AMW'(insn[25:24]);
        rs1     = insn[23:20];
        imm_raw = insn[19:0];
        if (insn[29:26] == BT_JSUB) rd = RIDX'(LINK_REG);
      end
      default: ;
    endcase
  end

  generate
    if (XLEN > RAWIW) begin : g_wide
      assign imm = {{(XLEN-RAWIW){1'b0}}, imm_raw};
    end else begin : g_narrow
      assign imm = imm_raw[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/dec_classify.sv
module dec_classify
  import insn_dec_pkg::*;
(
  input  cat_e             cat,
  input  logic [FUNCW-1:0] func,
  input  logic [BTW-1:0]   btype,
  output logic             is_nop,
  output logic             word_bad,
  output brk_e             kind_raw
);
  logic fn_ok;
  brk_e tk;

  always_comb begin
    fn_ok    = func_legal(func);
    tk       = type_kind(btype);
    is_nop   = (cat == CAT_ARITH) && (func == FN_NOP);
    kind_raw = (cat == CAT_FLOW) ? tk : BK_NONE;
    word_bad = ((cat == CAT_ARITH) && !fn_ok) ||
               ((cat == CAT_FLOW)  && (tk == BK_NONE));
  end
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import insn_dec_pkg::*;
(
  input  logic valid,
  input  cat_e cat,
  input  logic imm_flag,
  input  logic is_nop,
  input  logic word_bad,
  input  brk_e kind_raw,
  output logic reg_we,
  output logic mem_rd,
  output logic mem_wr,
  output logic use_imm,
  output brk_e br_kind,
  output logic stall,
  output logic illegal
);
  logic live;

  always_comb begin
    live    = valid && !word_bad;
    illegal = valid && word_bad;
    mem_rd  = live && (cat == CAT_LOAD);
    mem_wr  = live && (cat == CAT_STORE);
    stall   = live && is_nop;
    br_kind = live ? kind_raw : BK_NONE;
    use_imm = live && ((cat == CAT_LOAD) || (cat == CAT_STORE) ||
                       ((cat == CAT_ARITH) && imm_flag && !is_nop));
    reg_we  = live && ((cat == CAT_LOAD) ||
                       ((cat == CAT_ARITH) && !is_nop) ||
                       (kind_raw == BK_JSUB));
  end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import insn_dec_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LINK_REG = 15
) (
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  output logic [1:0]       cat_o,
  output logic [3:0]       rd_o,
  output logic [3:0]       rs1_o,
  output logic [3:0]       rs2_o,
  output logic [XLEN-1:0]  imm_o,
  output logic [5:0]       amode_o,
  output logic [4:0]       func_o,
  output logic [3:0]       btype_o,
  output logic             reg_we_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             use_imm_o,
  output logic [2:0]       br_kind_o,
  output logic             stall_o,
  output logic             illegal_o
);
  cat_e cat_w;
  logic imm_flag_w;
  logic is_nop_w;
  logic word_bad_w;
  brk_e kind_raw_w;
  brk_e br_kind_w;

  dec_fields #(.XLEN(XLEN), .LINK_REG(LINK_REG)) u_fields (
    .insn     (insn_i),
    .cat      (cat_w),
    .rd       (rd_o),
    .rs1      (rs1_o),
    .rs2      (rs2_o),
    .imm      (imm_o),
    .amode    (amode_o),
    .func     (func_o),
    .btype    (btype_o),
    .imm_flag (imm_flag_w)
  );

  dec_classify u_class (
    .cat      (cat_w),
    .func     (func_o),
    .btype    (btype_o),
    .is_nop   (is_nop_w),
    .word_bad (word_bad_w),
    .kind_raw (kind_raw_w)
  );

  dec_ctrl u_ctrl (
    .valid    (valid_i),
    .cat      (cat_w),
    .imm_flag (imm_flag_w),
    .is_nop   (is_nop_w),
    .word_bad (word_bad_w),
    .kind_raw (kind_raw_w),
    .reg_we   (reg_we_o),
    .mem_rd   (mem_rd_o),
    .mem_wr   (mem_wr_o),
    .use_imm  (use_imm_o),
    .br_kind  (br_kind_w),
    .stall    (stall_o),
    .illegal  (illegal_o)
  );

  assign cat_o     = cat_w;
  assign br_kind_o = br_kind_w;
endmodule

// File: rtl/insn_field_decoder_chk.sv
module insn_field_decoder_chk (
  input logic       valid_i,
  input logic [1:0] cat_o,
  input logic [3:0] rd_o,
  input logic       reg_we_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       use_imm_o,
  input logic [2:0] br_kind_o,
  input logic       stall_o,
  input logic       illegal_o,
  input logic       is_nop_w,
  input logic       word_bad_w
);
  always_comb begin
    AST_MEM_EXCLUSIVE: assert (!(mem_rd_o && mem_wr_o)) else $error("mem rd and wr together"); // R5
    AST_INVALID_QUIET: assert (valid_i || !(reg_we_o || mem_rd_o || mem_wr_o || use_imm_o || stall_o || illegal_o || (br_kind_o != 3'd0))) else $error("control active while invalid"); // R12
    AST_ILLEGAL_NO_WRITE: assert (!illegal_o || !(reg_we_o || mem_wr_o || stall_o || (br_kind_o != 3'd0))) else $error("write while illegal"); // R11
    AST_ILLEGAL_SOURCE: assert (illegal_o == (valid_i && word_bad_w)) else $error("illegal flag mismatch"); // R11
    AST_NOP_NO_WRITE: assert (!stall_o || (is_nop_w && !reg_we_o && !use_imm_o)) else $error("stall with write"); // R7
    AST_BRANCH_CATEGORY: assert ((br_kind_o == 3'd0) || (cat_o == 2'd3)) else $error("branch outside flow"); // R8
    AST_JSUB_LINK: assert ((br_kind_o != 3'd5) || (reg_we_o && rd_o == 4'd15)) else $error("subroutine jump without link"); // R9
  end
endmodule

bind insn_field_decoder insn_field_decoder_chk u_chk (
  .valid_i    (valid_i),
  .cat_o      (cat_o),
  .rd_o       (rd_o),
  .reg_we_o   (reg_we_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .use_imm_o  (use_imm_o),
  .br_kind_o  (br_kind_o),
  .stall_o    (stall_o),
  .illegal_o  (illegal_o),
  .is_nop_w   (is_nop_w),
  .word_bad_w (word_bad_w)
);

// File: tb/insn_field_decoder_tb.sv
`timescale 1ns/1ps
module insn_field_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        valid_i;
  logic [31:0] insn_i;
  logic [1:0]  cat_o;
  logic [3:0]  rd_o, rs1_o, rs2_o, btype_o;
  logic [31:0] imm_o;
  logic [5:0]  amode_o;
  logic [4:0]  func_o;
  logic        reg_we_o, mem_rd_o, mem_wr_o, use_imm_o, stall_o, illegal_o;
  logic [2:0]  br_kind_o;

  insn_field_decoder u_dut (
    .valid_i(valid_i), .insn_i(insn_i), .cat_o(cat_o), .rd_o(rd_o),
    .rs1_o(rs1_o), .rs2_o(rs2_o), .imm_o(imm_o), .amode_o(amode_o),
    .func_o(func_o), .btype_o(btype_o), .reg_we_o(reg_we_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .use_imm_o(use_imm_o),
    .br_kind_o(br_kind_o), .stall_o(stall_o), .illegal_o(illegal_o)
  );

  int applied = 0;
  int bad     = 0;
  int cycles  = 0;
  bit done    = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s word=%h valid=%0b actual=%h expected=%h",
               req, what, insn_i, valid_i, act, exp);
    end
  endtask

  // Independent model: legal function list and type numbering per R8, R11
  function automatic bit legal_fn(input int f);
    int ok[17] = '{0, 1, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 16, 18, 24, 28, 31};
    foreach (ok[i]) if (ok[i] == f) return 1;
    return 0;
  endfunction

  function automatic int kind_of(input int t);
    case (t)
      1: return 1;
      2: return 2;
      4: return 3;
      6: return 4;
      8: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic judge();
    logic [31:0] w;
    int c, f, t, k;
    int e_rd, e_rs1, e_rs2, e_am, e_fn, e_bt;
    logic [31:0] e_imm;
    bit we, mr, mw, ui, st, il;
    w = insn_i;
    c = int'(w[31:30]);
    e_rd = 0; e_rs1 = 0; e_rs2 = 0; e_am = 0; e_fn = 0; e_bt = 0; e_imm = 0;
    we = 0; mr = 0; mw = 0; ui = 0; st = 0; il = 0; k = 0;
    if (c == 0 || c == 1) begin
      e_am  = int'(w[29:24]);
      e_rs1 = int'(w[19:16]);
      e_imm = w & 32'h0000_FFFF;
      ui    = 1;
      if (c == 0) begin e_rd = int'(w[23:20]); we = 1; mr = 1; end
      else begin e_rs2 = int'(w[23:20]); mw = 1; end
    end else if (c == 2) begin
      f = int'(w[29:25]);
      e_fn = f; e_rd = int'(w[23:20]); e_rs1 = int'(w[19:16]);
      e_rs2 = int'(w[15:12]); e_imm = w % 4096;
      il = !legal_fn(f);
      st = !il && (f == 31);
      we = !il && !st;
      ui = we && w[24];
    end else begin
      t = int'(w[29:26]);
      e_bt = t; e_am = int'(w[25:24]); e_rs1 = int'(w[23:20]);
      e_imm = w % (1 << 20);
      k = kind_of(t);
      il = (k == 0);
      if (t == 8) e_rd = 15;
      we = (k == 5);
    end
    if (!valid_i) begin
      we = 0; mr = 0; mw = 0; ui = 0; st = 0; il = 0; k = 0;
    end
    check("R1", "cat", 32'(cat_o), 32'(c));
    check(c == 3 ? "R9" : (c == 2 ? "R3" : "R2"), "rd", 32'(rd_o), 32'(e_rd));
    check(c == 2 ? "R3" : (c == 3 ? "R4" : "R2"), "rs1", 32'(rs1_o), 32'(e_rs1));
    check(c == 2 ? "R3" : (c == 3 ? "R4" : "R2"), "rs2", 32'(rs2_o), 32'(e_rs2));
    check(c == 2 ? "R3" : (c == 3 ? "R4" : "R2"), "imm", imm_o, e_imm);
    check(c == 3 ? "R4" : (c == 2 ? "R3" : "R2"), "amode", 32'(amode_o), 32'(e_am));
    check("R4", "func", 32'(func_o), 32'(e_fn));
    check("R4", "btype", 32'(btype_o), 32'(e_bt));
    check(valid_i ? "R10" : "R12", "reg_we", 32'(reg_we_o), 32'(we));
    check(valid_i ? "R5" : "R12", "mem_rd", 32'(mem_rd_o), 32'(mr));
    check(valid_i ? "R5" : "R12", "mem_wr", 32'(mem_wr_o), 32'(mw));
    check(valid_i ? "R6" : "R12", "use_imm", 32'(use_imm_o), 32'(ui));
    check(valid_i ? "R7" : "R12", "stall", 32'(stall_o), 32'(st));
    check(valid_i ? "R11" : "R12", "illegal", 32'(illegal_o), 32'(il));
    check(valid_i ? "R8" : "R12", "br_kind", 32'(br_kind_o), 32'(k));
  endtask

  task automatic apply(input logic v, input logic [31:0] w);
    @(posedge clk);
    valid_i = v;
    insn_i  = w;
    @(negedge clk);
    judge();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    valid_i = 1'b0;
    insn_i  = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: valid low, all controls quiet (R12)
    check("R12", "reg_we", 32'(reg_we_o), 0);
    check("R12", "br_kind", 32'(br_kind_o), 0);
    // Directed: subroutine jump links to 15 (R9)
    apply(1'b1, {2'b11, 4'b1000, 2'b01, 4'h3, 20'hABCDE});
    check("R9", "link rd", 32'(rd_o), 15);
    check("R9", "link we", 32'(reg_we_o), 1);
    // Directed: no-op with immediate flag set (R7)
    apply(1'b1, {2'b10, 5'b11111, 1'b1, 24'h123456});
    check("R7", "nop stall", 32'(stall_o), 1);
    check("R7", "nop use_imm", 32'(use_imm_o), 0);
    // Directed: absolute target, full 20 bits (R4)
    apply(1'b1, {2'b11, 4'b0100, 2'b00, 4'h0, 20'hFFFFF});
    check("R4", "target", imm_o, 32'h000F_FFFF);
    // Sweep: every category, every value of bits 29:24, valid low and high
    seed = 32'h1357_9BDF;
    for (int rep = 0; rep < 6; rep++) begin
      for (int c = 0; c < 4; c++) begin
        for (int hi = 0; hi < 64; hi++) begin
          for (int v = 0; v < 2; v++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            apply(v[0], {c[1:0], hi[5:0], seed[31:8]});
          end
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule